// File: doc/BRIEF.md
# Synchronous Half-Duplex Byte Shifter

This block moves one byte at a time over a synchronous serial link made of one shared data line and one shift clock that the block drives itself. A single-cycle write of a byte queues a transmit. The transmit starts on the next bit-slot boundary and sends the bits least-significant first. Raising the receive enable while the receive-done flag is low starts a receive. The receive clocks eight bits in, least-significant first, and presents the assembled byte. Only one direction is active at a time.

The end of each frame is not counted. A marker bit travels through the shift register instead. For transmit, a single 1 sits above the eight data bits and zeros fill in behind it. For receive, a lone 0 sits among ones and moves toward the far end as samples arrive. Two configuration inputs set the idle clock level and how the data edges relate to the clock pulse. Sticky done flags mark each finished frame, and the controlling logic clears them. Start, stop and acknowledge framing, pin multiplexing and the tri-state pad are outside the block. The data line is presented as separate input, output and output-enable signals.

Top module: `sss_shift_serial`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sd_oe`, `tx_done` and `rx_done` are 0, `rx_data` is 0, and `sclk` is at its idle level.
- R2: A `buf_wr` pulse is accepted only when no transmit is pending or sending and no receive is active. `sd_oe` rises on the next slot boundary, within 1 to `SLOT_CLKS` cycles of the accepting edge. Writes that are not accepted leave the pending byte and the ongoing frame unchanged.
- R3: A transmit drives `sd_oe` high for exactly 8 slots, and `sd_o` carries bit i of the byte during slot i (i = 0 first). `tx_done` becomes 1 on the edge that ends the eighth slot.
- R4: A receive starts on a slot boundary only when `rx_en` is 1, `rx_done` is 0, no transmit is pending, accepted or active, and no receive is active. A pending transmit has priority, and transmit and receive are never active together.
- R5: A receive samples `sd_i` once per slot, 8 times. Sample k becomes bit k of `rx_data`. On the eighth sample, `rx_data` is updated, the receive ends and `rx_done` is set.
- R6: When no frame is active, `sclk` rests high if `clk_pol` is 0 and low if `clk_pol` is 1, and it does not toggle.
- R7: While a frame is active, with slot position p in 0..`SLOT_CLKS`-1 and Q = `SLOT_CLKS`/4, `sclk` is non-idle when `hold_both`=0 and p < 2Q, or when `hold_both`=1 and Q <= p < 3Q. Data changes at p=0. Receive samples are taken on the edge that enters p=2Q (`hold_both`=0) or p=3Q (`hold_both`=1).
- R8: `tx_done` and `rx_done` stay set until the matching clear pulse. A set in the same cycle wins over the clear. While `rx_done` is 1, no new receive starts.
- R9: A bit slot lasts `SLOT_CLKS` system clocks (default 12, a multiple of 4). The slot counter runs freely from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_pol | input | 1 | 0: clock idles high, 1: clock idles low |
| hold_both | input | 1 | 0: data changes with the leading clock edge; 1: data stable across both edges |
| buf_wr | input | 1 | One-cycle write strobe of the transmit byte |
| buf_wdata | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| clr_tx_done | input | 1 | Clears `tx_done` |
| clr_rx_done | input | 1 | Clears `rx_done` |
| sd_i | input | 1 | Data line as seen at the pad |
| sd_o | output | 1 | Data value to drive |
| sd_oe | output | 1 | Drive enable for the data line (1 during transmit) |
| sclk | output | 1 | Shift clock |
| rx_data | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit finished flag |
| rx_done | output | 1 | Receive finished flag |

## Verification
The assertions assume that `clk_pol` and `hold_both` change only while no frame is pending or active, and that the clear strobes are single pulses. The bench changes the two mode inputs only after both done flags have been seen and no transfer is queued. It walks all four mode combinations. It changes `sd_i` only at falling clock edges, so every sample sees a settled value.

// File: rtl/sss_pkg.sv
package sss_pkg;
  // Per-cycle events from the bit-slot divider
  typedef struct packed {
    logic eos;    // last cycle of a slot
    logic smp;    // receive sample edge follows
    logic pulse;  // clock should be at its non-idle level
  } slot_ev_t;
endpackage

// File: rtl/sss_slot_timer.sv
module sss_slot_timer
  import sss_pkg::*;
#(
  parameter int SLOT_CLKS = 12,
  parameter int PW = $clog2(SLOT_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_both,
  output logic [PW-1:0] pos,
  output slot_ev_t      ev
);
  localparam int Q = SLOT_CLKS / 4;
  localparam logic [PW-1:0] LAST  = PW'(SLOT_CLKS - 1);
  localparam logic [PW-1:0] P_Q   = PW'(Q);
  localparam logic [PW-1:0] P_2Q  = PW'(2 * Q);
  localparam logic [PW-1:0] P_3Q  = PW'(3 * Q);

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (pos == LAST) pos <= '0;
    else pos <= pos + 1'b1;
  end

  always_comb begin
    ev.eos = (pos == LAST);
    if (hold_both) begin
      ev.smp   = (pos == P_3Q - 1'b1);
      ev.pulse = (pos >= P_Q) && (pos < P_3Q);
    end else begin
      ev.smp   = (pos == P_2Q - 1'b1);
      ev.pulse = (pos < P_2Q);
    end
  end

  assert_slot_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (pos == LAST) |=> (pos == '0));
endmodule

// File: rtl/sss_tx.sv
module sss_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       eos,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       rx_busy,
  input  logic       clr_done,
  output logic       accept,
  output logic       pending,
  output logic       active,
  output logic       bit_out,
  output logic       done
);
  logic [8:0] sr;
  logic       last_bit;

  assign accept   = wr && !pending && !active && !rx_busy;
  assign last_bit = (sr[8:2] == '0);
  assign bit_out  = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= 9'h001;
      pending <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        sr      <= {1'b1, wdata};
        pending <= 1'b1;
      end
      if (eos) begin
        if (active) begin
          sr <= {1'b0, sr[8:1]};
          if (last_bit) active <= 1'b0;
        end else if (pending) begin
          active  <= 1'b1;
          pending <= 1'b0;
        end
      end
      if (eos && active && last_bit) done <= 1'b1;
      else if (clr_done)             done <= 1'b0;
    end
  end

  assert_tx_marker_R3: assert property (@(posedge clk) disable iff (rst)
    active |-> (sr[8:1] != '0));
  assert_tx_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !clr_done) |=> done);
  assert_tx_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(pending && active));
endmodule

// File: rtl/sss_rx.sv
module sss_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       smp,
  input  logic       din,
  input  logic       clr_done,
  output logic       active,
  output logic       done,
  output logic [7:0] data
);
  logic [7:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= 8'hFF;
      active <= 1'b0;
      done   <= 1'b0;
      data   <= '0;
    end else begin
      if (start) begin
        sr     <= 8'h7F;
        active <= 1'b1;
      end else if (active && smp) begin
        sr <= {din, sr[7:1]};
        if (!sr[0]) begin
          data   <= {din, sr[7:1]};
          active <= 1'b0;
        end
      end
      if (active && smp && !sr[0]) done <= 1'b1;
      else if (clr_done)           done <= 1'b0;
    end
  end

  assert_rx_gate_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(!done));
  assert_rx_sentinel_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> (sr != 8'hFF));
  assert_rx_end_flag_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> done);
endmodule

// File: rtl/sss_shift_serial.sv
module sss_shift_serial
  import sss_pkg::*;
#(
  parameter int SLOT_CLKS = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clk_pol,
  input  logic       hold_both,
  input  logic       buf_wr,
  input  logic [7:0] buf_wdata,
  input  logic       rx_en,
  input  logic       clr_tx_done,
  input  logic       clr_rx_done,
  input  logic       sd_i,
  output logic       sd_o,
  output logic       sd_oe,
  output logic       sclk,
  output logic [7:0] rx_data,
  output logic       tx_done,
  output logic       rx_done
);
  localparam int PW = $clog2(SLOT_CLKS);

  logic [PW-1:0] pos;
  slot_ev_t      ev;
  logic          tx_accept, tx_pending, tx_active;
  logic          rx_active, rx_start;

  sss_slot_timer #(.SLOT_CLKS(SLOT_CLKS), .PW(PW)) u_timer (
    .clk(clk), .rst(rst), .hold_both(hold_both), .pos(pos), .ev(ev)
  );

  sss_tx u_tx (
    .clk(clk), .rst(rst), .eos(ev.eos), .wr(buf_wr), .wdata(buf_wdata),
    .rx_busy(rx_active), .clr_done(clr_tx_done), .accept(tx_accept),
    .pending(tx_pending), .active(tx_active), .bit_out(sd_o), .done(tx_done)
  );

  assign rx_start = ev.eos && rx_en && !rx_done && !rx_active &&
                    !tx_pending && !tx_accept && !tx_active;

  sss_rx u_rx (
    .clk(clk), .rst(rst), .start(rx_start), .smp(ev.smp), .din(sd_i),
    .clr_done(clr_rx_done), .active(rx_active), .done(rx_done), .data(rx_data)
  );

  assign sd_oe = tx_active;
  // Idle level is the inverse of clk_pol; pulse flips it while a frame runs
  assign sclk  = !clk_pol ^ ((tx_active || rx_active) && ev.pulse);

  assert_half_duplex_R4: assert property (@(posedge clk) disable iff (rst)
    !(tx_active && rx_active));
  assert_idle_clk_R6: assert property (@(posedge clk) disable iff (rst)
    !(tx_active || rx_active) |-> (sclk == !clk_pol));
  assert_tx_slot_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> (pos == '0));
endmodule

// File: tb/sss_shift_serial_tb.sv
module sss_shift_serial_tb;
  localparam int SLOT = 12;
  localparam int Q = SLOT / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_pol = 1'b0, hold_both = 1'b0, buf_wr = 1'b0, rx_en = 1'b0;
  logic clr_tx_done = 1'b0, clr_rx_done = 1'b0, sd_i = 1'b1;
  logic [7:0] buf_wdata = '0;
  logic sd_o, sd_oe, sclk, tx_done, rx_done;
  logic [7:0] rx_data;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sss_shift_serial #(.SLOT_CLKS(SLOT)) u_dut (
    .clk(clk), .rst(rst), .clk_pol(clk_pol), .hold_both(hold_both),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .rx_en(rx_en),
    .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done), .sd_i(sd_i),
    .sd_o(sd_o), .sd_oe(sd_oe), .sclk(sclk), .rx_data(rx_data),
    .tx_done(tx_done), .rx_done(rx_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_pos = 0, rcnt = 0;
  bit  m_pend = 0, m_send = 0, m_recv = 0, m_tdone = 0, m_rdone = 0, m_cur = 1;
  bit  txq[$];
  logic [7:0] m_rdata = '0, rbyte = '0;

  always @(posedge clk) begin
    bit eos, smp, acc, rxs, tset, rset;
    if (rst) begin
      m_pos = 0; m_pend = 0; m_send = 0; m_recv = 0; m_tdone = 0; m_rdone = 0;
      m_rdata = '0; m_cur = 1; txq.delete();
    end else begin
      eos  = (m_pos == SLOT - 1);
      smp  = (m_pos == (hold_both ? 3 * Q - 1 : 2 * Q - 1));
      acc  = buf_wr && !m_pend && !m_send && !m_recv;
      rxs  = eos && rx_en && !m_rdone && !m_send && !m_pend && !acc && !m_recv;
      tset = 0; rset = 0;
      if (eos && m_send) begin
        void'(txq.pop_front());
        if (txq.size() == 0) begin m_send = 0; tset = 1; end
        else m_cur = txq[0];
      end else if (eos && m_pend) begin
        m_send = 1; m_pend = 0; m_cur = txq[0];
      end
      if (acc) begin
        txq.delete();
        for (int i = 0; i < 8; i++) txq.push_back(buf_wdata[i]);
        m_pend = 1;
      end
      if (rxs) begin
        m_recv = 1; rcnt = 0; rbyte = '0;
      end else if (m_recv && smp) begin
        rbyte[rcnt] = sd_i;
        rcnt++;
        if (rcnt == 8) begin m_recv = 0; m_rdata = rbyte; rset = 1; end
      end
      if (tset) m_tdone = 1; else if (clr_tx_done) m_tdone = 0;
      if (rset) m_rdone = 1; else if (clr_rx_done) m_rdone = 0;
      m_pos = eos ? 0 : m_pos + 1;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit pulse, exp_clk;
    if (!rst && !finished) begin
      pulse   = hold_both ? (m_pos >= Q && m_pos < 3 * Q) : (m_pos < 2 * Q);
      exp_clk = !clk_pol ^ ((m_send || m_recv) && pulse);
      if (m_send || m_recv) chk(sclk == exp_clk, "R7 sclk phase", sclk, exp_clk);
      else                  chk(sclk == exp_clk, "R6 sclk idle", sclk, exp_clk);
      chk(sd_oe == m_send, "R3 sd_oe", sd_oe, m_send);
      if (m_send) chk(sd_o == m_cur, "R3 sd_o bit", sd_o, m_cur);
      chk(tx_done == m_tdone, "R8 tx_done", tx_done, m_tdone);
      chk(rx_done == m_rdone, "R4 rx_done", rx_done, m_rdone);
      chk(rx_data == m_rdata, "R5 rx_data", rx_data, m_rdata);
    end
    if (!finished) sd_i <= $urandom_range(0, 1);
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R9 watchdog: cycles=%0d expected<60000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    buf_wdata = b; buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic do_tx(input logic [7:0] b);
    int lat, len;
    write_byte(b);
    // Second write while pending: must be ignored (R2)
    write_byte(~b);
    lat = 2;
    while (!sd_oe && lat < 4 * SLOT) begin @(negedge clk); lat++; end
    chk(lat >= 1 && lat <= SLOT + 1, "R2 start latency", lat, SLOT);
    len = 0;
    while (sd_oe && len < 20 * SLOT) begin
      if (len == 3 * SLOT) write_byte(8'h00); else @(negedge clk);
      len++;
    end
    chk(len == 8 * SLOT, "R9 send length", len, 8 * SLOT);
    chk(tx_done == 1'b1, "R3 tx_done at end", tx_done, 1);
    clr_tx_done = 1'b1; @(negedge clk); clr_tx_done = 1'b0;
  endtask

  task automatic do_rx();
    int w;
    rx_en = 1'b1;
    w = 0;
    while (!rx_done && w < 20 * SLOT) begin
      if (w == 2 * SLOT) write_byte(8'hFF); else @(negedge clk);
      w++;
    end
    chk(rx_done == 1'b1, "R5 rx_done set", rx_done, 1);
    // rx_en still high with rx_done set: no new receive (R8)
    tick(3 * SLOT);
    chk(sclk == !clk_pol, "R8 no restart while done", sclk, !clk_pol);
    rx_en = 1'b0;
    clr_rx_done = 1'b1; @(negedge clk); clr_rx_done = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(4);
    chk(sd_oe == 1'b0, "R1 reset sd_oe", sd_oe, 0);
    chk(tx_done == 1'b0 && rx_done == 1'b0, "R1 reset flags", {tx_done, rx_done}, 0);
    chk(rx_data == 8'h00, "R1 reset rx_data", rx_data, 0);
    chk(sclk == 1'b1, "R1 reset sclk idle", sclk, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b1 && sd_oe == 1'b0, "R1 after reset", {sclk, sd_oe}, 2);
    for (int m = 0; m < 4; m++) begin
      clk_pol   = m[0];
      hold_both = m[1];
      tick(2);
      do_tx(8'hA5 ^ 8'(m * 37));
      do_rx();
      // Write and enable together: transmit wins (R4)
      rx_en = 1'b1;
      write_byte(8'h5A);
      while (!tx_done) @(negedge clk);
      clr_tx_done = 1'b1; @(negedge clk); clr_tx_done = 1'b0;
      while (!rx_done) @(negedge clk);
      rx_en = 1'b0;
      // clear and set flags: clear pulse honoured
      clr_rx_done = 1'b1; @(negedge clk); clr_rx_done = 1'b0;
      tick(SLOT);
      chk(rx_done == 1'b0, "R8 clear rx_done", rx_done, 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule